// File: doc/BRIEF.md
# Bus Transmit Dominant Time-Out Guard

This block sits between the transmit data input of a single-wire bus transceiver and the enable of its low-side bus driver. While the transceiver is in its normal (communicating) mode, a low transmit level pulls the bus dominant. A high level leaves the bus recessive. The guard stops a stuck-low transmit line from holding the bus dominant for good. When the low level lasts longer than a time-out, the driver is released and stays released until the transmit line has been high for a minimum re-arm period. The same re-arm rule applies when normal mode starts while the transmit line is already low, so that a shorted pin cannot drive the bus at mode entry.

An overtemperature flag releases the driver for as long as it is set. The received bus level is passed back to the controller only in normal mode, and it reads high (recessive) otherwise. The raw transmit level is forwarded unchanged to the mode-selection logic. A stuck-low line can therefore still request the low-power sleep mode after the time-out has fired. All timing is counted in ticks of a prescaled clock. `DIV` clock cycles make one tick, the time-out is `TOUT_TICKS` ticks, and the re-arm period is `REARM_TICKS` ticks.

Top module: `txd_timeout_guard`

## Requirements
- R1: During and right after reset, with normal mode low, bus_drive is 0, timeout_flag is 0 and rxd is 1.
- R2: In normal mode with the guard armed and overtemp low, bus_drive equals the inverse of txd (txd 0 gives bus_drive 1).
- R3: When txd has been sampled low on DIV*TOUT_TICKS consecutive rising clock edges while armed, bus_drive goes to 0 and timeout_flag goes to 1 from that edge on, even though txd stays low.
- R4: After a time-out, the guard re-arms only after txd has been sampled high on DIV*REARM_TICKS consecutive edges. A shorter high period restarts the count, and re-arming clears timeout_flag.
- R5: If txd is low on the edge at which normal mode is first seen, bus_drive stays 0 until txd has been sampled high on DIV*REARM_TICKS consecutive edges. timeout_flag stays 0 throughout.
- R6: overtemp high forces bus_drive to 0 within the same cycle, and bus_drive follows txd again as soon as overtemp is low.
- R7: rxd equals bus_level (1 for recessive, 0 for dominant) while normal_mode is 1, and rxd is 1 while normal_mode is 0.
- R8: With normal_mode at 0, bus_drive is 0 whatever the txd level. One edge with normal_mode at 0 clears timeout_flag and any pending re-arm hold.
- R9: txd_to_mode always equals txd, including while the time-out holds the driver released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txd | input | 1 | Transmit data from the controller, 0 requests dominant |
| normal_mode | input | 1 | 1 while the transceiver is in normal mode |
| overtemp | input | 1 | Driver overtemperature flag |
| bus_level | input | 1 | Received bus level, 1 recessive |
| bus_drive | output | 1 | Driver enable, 1 pulls the bus dominant |
| rxd | output | 1 | Received data to the controller |
| txd_to_mode | output | 1 | Raw transmit level forwarded to mode logic |
| timeout_flag | output | 1 | 1 from a time-out until re-arm or normal mode exit |

## Verification
A wrong count or a prescaler left in the wrong phase shows up at bus_drive as an edge off by one or more cycles. The bench sweeps the low and high durations one cycle at a time around each limit, so either error is caught at the first length that crosses a threshold. A state not cleared on mode exit shows up as a driver that stays blocked, or a flag that stays set, on the first check after normal mode is entered again. Because bus_drive and rxd are combinational in the current state, a wrong state is visible in the same cycle it is entered.

// File: rtl/txd_timeout_guard.sv
module txd_timeout_guard #(
  parameter int DIV         = 20,
  parameter int TOUT_TICKS  = 40000,
  parameter int REARM_TICKS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd,
  input  logic normal_mode,
  input  logic overtemp,
  input  logic bus_level,
  output logic bus_drive,
  output logic rxd,
  output logic txd_to_mode,
  output logic timeout_flag
);

  localparam int PW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int MAXT = (TOUT_TICKS > REARM_TICKS) ? TOUT_TICKS : REARM_TICKS;
  localparam int TW   = $clog2(MAXT + 1);
  localparam logic [PW-1:0] PRE_LAST  = PW'(DIV - 1);
  localparam logic [TW-1:0] TOUT_LAST = TW'(TOUT_TICKS - 1);
  localparam logic [TW-1:0] REARM_LAST = TW'(REARM_TICKS - 1);

  typedef enum logic [1:0] {S_OFF, S_ARMED, S_HOLD} guard_state_t;

  guard_state_t st;
  logic [PW-1:0] pre;
  logic [TW-1:0] ticks;
  logic          run, tick, done;
  logic [TW-1:0] limit;

  assign run   = (st == S_ARMED && !txd) || (st == S_HOLD && txd);
  assign limit = (st == S_ARMED) ? TOUT_LAST : REARM_LAST;
  assign tick  = (pre == PRE_LAST);
  assign done  = run && tick && (ticks == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_OFF;
      pre          <= '0;
      ticks        <= '0;
      timeout_flag <= 1'b0;
    end else if (!normal_mode) begin
      st           <= S_OFF;
      pre          <= '0;
      ticks        <= '0;
      timeout_flag <= 1'b0;
    end else if (st == S_OFF) begin
      st    <= txd ? S_ARMED : S_HOLD;
      pre   <= '0;
      ticks <= '0;
    end else if (done) begin
      st           <= (st == S_ARMED) ? S_HOLD : S_ARMED;
      timeout_flag <= (st == S_ARMED);
      pre          <= '0;
      ticks        <= '0;
    end else if (run) begin
      pre <= tick ? '0 : pre + PW'(1);
      if (tick && ticks != limit) ticks <= ticks + TW'(1);
    end else begin
      pre   <= '0;
      ticks <= '0;
    end
  end

  assign bus_drive   = normal_mode && (st == S_ARMED) && !txd && !overtemp;
  assign rxd         = normal_mode ? bus_level : 1'b1;
  assign txd_to_mode = txd;

endmodule

// File: rtl/txd_timeout_guard_checks.sv
module txd_timeout_guard_checks #(
  parameter int DIV        = 20,
  parameter int TOUT_TICKS = 40000
) (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic normal_mode,
  input logic overtemp,
  input logic bus_drive,
  input logic timeout_flag
);
  localparam int TL = DIV * TOUT_TICKS;
  int unsigned dom_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dom_run <= 0;
    else if (bus_drive) dom_run <= dom_run + 1;
    else dom_run <= 0;
  end

  assert_dom_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> dom_run < TL);

  assert_flag_after_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> $past(!txd && normal_mode));

  assert_rearm_after_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(timeout_flag) && $past(normal_mode) && normal_mode) |-> $past(txd));

  assert_entry_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(normal_mode) && !txd) |=> !bus_drive);

  assert_hot_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overtemp |-> !bus_drive);

  assert_exit_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !normal_mode |=> !timeout_flag);
endmodule

bind txd_timeout_guard txd_timeout_guard_checks #(.DIV(DIV), .TOUT_TICKS(TOUT_TICKS)) u_checks (
  .clk(clk), .rst_n(rst_n), .txd(txd), .normal_mode(normal_mode),
  .overtemp(overtemp), .bus_drive(bus_drive), .timeout_flag(timeout_flag)
);

// File: tb/tb_txd_timeout_guard.sv
module tb_txd_timeout_guard;
  localparam int DIV = 2, TOUT = 4, REARM = 3;
  localparam int TL = DIV * TOUT;
  localparam int RL = DIV * REARM;

  logic clk = 1'b0, rst_n = 1'b0;
  logic txd = 1'b1, normal_mode = 1'b0, overtemp = 1'b0, bus_level = 1'b1;
  logic bus_drive, rxd, txd_to_mode, timeout_flag;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  txd_timeout_guard #(.DIV(DIV), .TOUT_TICKS(TOUT), .REARM_TICKS(REARM)) dut (
    .clk(clk), .rst_n(rst_n), .txd(txd), .normal_mode(normal_mode),
    .overtemp(overtemp), .bus_level(bus_level), .bus_drive(bus_drive),
    .rxd(rxd), .txd_to_mode(txd_to_mode), .timeout_flag(timeout_flag));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic enter_normal(input logic lvl);
    @(negedge clk); normal_mode = 1'b0;
    @(negedge clk); txd = lvl; normal_mode = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #2;
    check("R1 drive", bus_drive, 1'b0);
    check("R1 flag", timeout_flag, 1'b0);
    check("R1 rxd", rxd, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    #2;
    check("R1 drive after release", bus_drive, 1'b0);

    for (int len = 1; len <= 12; len++) begin
      enter_normal(1'b1);
      txd = 1'b0; #2;
      check("R2 dominant", bus_drive, 1'b1);
      for (int j = 1; j <= len; j++) begin
        @(negedge clk); #2;
        check((j < TL) ? "R2 low held" : "R3 time-out drive", bus_drive, j < TL);
        check("R3 flag", timeout_flag, j >= TL);
      end
      txd = 1'b1; #2;
      check("R2 recessive", bus_drive, 1'b0);
    end

    for (int h = 0; h <= 8; h++) begin
      enter_normal(1'b1);
      txd = 1'b0;
      repeat (TL) @(negedge clk);
      #2;
      check("R9 raw low", txd_to_mode, 1'b0);
      txd = 1'b1; #2;
      check("R9 raw high", txd_to_mode, 1'b1);
      repeat (h) @(negedge clk);
      txd = 1'b0; #2;
      check("R4 rearm drive", bus_drive, h >= RL);
      check("R4 flag", timeout_flag, h < RL);
      txd = 1'b1;
    end

    for (int h = 0; h <= 8; h++) begin
      @(negedge clk); normal_mode = 1'b0; txd = 1'b0;
      @(negedge clk); normal_mode = 1'b1;
      @(negedge clk); #2;
      check("R5 entry blocked", bus_drive, 1'b0);
      txd = 1'b1;
      repeat (h) @(negedge clk);
      txd = 1'b0; #2;
      check("R5 entry rearm", bus_drive, h >= RL);
      check("R5 flag", timeout_flag, 1'b0);
      txd = 1'b1;
    end

    enter_normal(1'b1);
    txd = 1'b0; overtemp = 1'b1; #2;
    check("R6 hot", bus_drive, 1'b0);
    @(negedge clk); overtemp = 1'b0; #2;
    check("R6 cooled", bus_drive, 1'b1);
    txd = 1'b1;

    for (int n = 0; n < 2; n++)
      for (int b = 0; b < 2; b++) begin
        @(negedge clk); normal_mode = n[0]; bus_level = b[0]; #2;
        check("R7 rxd", rxd, n[0] ? b[0] : 1'b1);
      end
    bus_level = 1'b1;

    enter_normal(1'b1);
    txd = 1'b0;
    repeat (TL) @(negedge clk);
    #2;
    check("R8 pre flag", timeout_flag, 1'b1);
    normal_mode = 1'b0;
    @(negedge clk); #2;
    check("R8 flag cleared", timeout_flag, 1'b0);
    check("R8 drive off", bus_drive, 1'b0);
    txd = 1'b1;
    @(negedge clk); normal_mode = 1'b1;
    @(negedge clk); txd = 1'b0; #2;
    check("R8 fresh entry armed", bus_drive, 1'b1);
    txd = 1'b1;

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule